// File: doc/BRIEF.md
# Adaptive-Bandwidth Bang-Bang Fine Tuning Controller

This block is the fine tuning controller of a duty-cycled, all-digital clock synthesizer. It holds a 9-bit fine oscillator code. At the end of each active burst it receives a one-bit early/late decision. The decision tells whether the oscillator edge just past the programmed edge count came before or after the closing reference edge. The controller moves the code one step in the direction that pulls that edge onto the reference edge. Between bursts the code is held, so that tuning picks up where it stopped.

The loop runs only while the coarse loop reports zero coarse error. When coarse lock is missing, the fine code is parked at mid-scale and the loop is reset to its wide setting. Acquisition starts with a large step. After the decision has reversed direction a set number of times, the loop takes this as a sign that it is dithering around the target and falls back to a step of one code.

Top module: `fine_bb_loop`

## Requirements
- R1: After reset, `fine_code` is 256 (mid-scale) and `bw_low` is 0.
- R2: On every clock edge where `coarse_lock` is 0, the next `fine_code` is 256 and `bw_low` is 0. The sign-change count and the stored previous decision are cleared.
- R3: On a clock edge where `coarse_lock` and `dec_valid` are both 1, a `dec_late` of 1 (the oscillator edge arrived after the reference edge) raises `fine_code` by the current step. A `dec_late` of 0 lowers it by the current step.
- R4: On a clock edge where `coarse_lock` is 1 and `dec_valid` is 0, `fine_code` and `bw_low` keep their values.
- R5: While `bw_low` is 0 the step is 16 codes. While `bw_low` is 1 the step is 1 code.
- R6: A sign change is an accepted decision whose `dec_late` differs from the previous accepted decision taken since lock was last gained. The edge that accepts the fourth sign change sets `bw_low` to 1 and still uses the step of 16. `bw_low` then stays 1 until coarse lock is lost or reset is applied.
- R7: `fine_code` saturates: a step up never goes above 511 and a step down never goes below 0. A move that would cross a limit lands on that limit.
- R8: Decisions presented while `coarse_lock` is 0 have no effect on the code or on the sign-change history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coarse_lock | input | 1 | 1 when the coarse loop reports zero coarse error |
| dec_valid | input | 1 | Single-cycle strobe at the end of an active burst |
| dec_late | input | 1 | Early/late decision: 1 = late (code rises), 0 = early (code falls) |
| fine_code | output | 9 | Fine oscillator code |
| bw_low | output | 1 | 1 once the loop has moved to the narrow step |

## Verification
The case that is hardest to reach is the change of bandwidth. It needs exactly four reversals among decisions taken in one unbroken lock interval, and a reversal counted across a lock drop would be wrong. A second hard case is saturation while the step is still wide, where a full 16-code move must be clipped. The stimulus builds these on purpose. Alternating decisions produce the reversals, one of them split by a lock drop. A long run of same-direction decisions drives the code to each limit. A long random phase follows, with rare lock drops and sparse strobes, checked every cycle against a behavioural model.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  // Saturating move of a code by a step; limits are 0 and max_code.
  function automatic int unsigned sat_move(input int unsigned code,
                                           input int unsigned step,
                                           input logic up,
                                           input int unsigned max_code);
    int unsigned r;
    if (up) begin
      r = (code + step > max_code) ? max_code : code + step;
    end else begin
      r = (step > code) ? 0 : code - step;
    end
    return r;
  endfunction
endpackage

// File: rtl/fbl_bw_ctrl.sv
module fbl_bw_ctrl #(
  parameter int FLIP_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic late,
  output logic narrow,
  output logic flip_evt
);
  localparam int CNT_W = $clog2(FLIP_LIMIT + 1);

  logic             have_prev;
  logic             prev_late;
  logic [CNT_W-1:0] flips;
  logic             narrow_q;

  assign flip_evt = upd && have_prev && (late != prev_late);
  assign narrow   = narrow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_late <= 1'b0;
      flips     <= '0;
      narrow_q  <= 1'b0;
    end else if (clr) begin
      have_prev <= 1'b0;
      prev_late <= 1'b0;
      flips     <= '0;
      narrow_q  <= 1'b0;
    end else if (upd) begin
      have_prev <= 1'b1;
      prev_late <= late;
      if (flip_evt && !narrow_q) begin
        flips <= flips + 1'b1;
        if (flips == CNT_W'(FLIP_LIMIT - 1)) narrow_q <= 1'b1;
      end
    end
  end

  AST_NARROW_NEEDS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(narrow_q) |-> $past(flip_evt)); // R6
  AST_NARROW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_q && !clr) |=> narrow_q); // R6
  AST_CLR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !narrow_q); // R2
endmodule

// File: rtl/fbl_code_acc.sv
module fbl_code_acc #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              late,
  input  logic [CODE_W-1:0] step,
  output logic [CODE_W-1:0] code
);
  import fbl_pkg::*;
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MID_CODE = 1 << (CODE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nx;

  always_comb begin
    code_nx = CODE_W'(sat_move(int'(code_q), int'(step), late, MAX_CODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= CODE_W'(MID_CODE);
    else if (clr)    code_q <= CODE_W'(MID_CODE);
    else if (upd)    code_q <= code_nx;
  end

  assign code = code_q;

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(code_q)); // R4
  AST_PARK_MID: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code_q == CODE_W'(MID_CODE))); // R2
  AST_MOVE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && late && code_q != CODE_W'(MAX_CODE)) |=> (code_q > $past(code_q))); // R3
  AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && !late && code_q != '0) |=> (code_q < $past(code_q))); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && late && code_q == CODE_W'(MAX_CODE)) |=> (code_q == CODE_W'(MAX_CODE))); // R7
endmodule

// File: rtl/fine_bb_loop.sv
module fine_bb_loop #(
  parameter int CODE_W      = 9,
  parameter int STEP_WIDE   = 16,
  parameter int STEP_NARROW = 1,
  parameter int FLIP_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coarse_lock,
  input  logic              dec_valid,
  input  logic              dec_late,
  output logic [CODE_W-1:0] fine_code,
  output logic              bw_low
);
  logic              clr;
  logic              upd;
  logic              narrow;
  logic              flip_evt;
  logic [CODE_W-1:0] step;

  assign clr  = !coarse_lock;
  assign upd  = coarse_lock && dec_valid;
  assign step = narrow ? CODE_W'(STEP_NARROW) : CODE_W'(STEP_WIDE);

  fbl_bw_ctrl #(.FLIP_LIMIT(FLIP_LIMIT)) bw_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .late(dec_late),
    .narrow(narrow), .flip_evt(flip_evt)
  );

  fbl_code_acc #(.CODE_W(CODE_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .late(dec_late),
    .step(step), .code(fine_code)
  );

  assign bw_low = narrow;

  AST_IGNORE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_lock && dec_valid) |=> (!bw_low && fine_code == CODE_W'(1 << (CODE_W - 1)))); // R8
  AST_FLIP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |-> (coarse_lock && dec_valid)); // R6
endmodule

// File: tb/fine_bb_loop_tb.sv
`timescale 1ns/1ps
module fine_bb_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coarse_lock = 1'b0;
  logic       dec_valid = 1'b0;
  logic       dec_late = 1'b0;
  logic [8:0] fine_code;
  logic       bw_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R1";

  int m_code = 256;
  int m_narrow = 0;
  int m_flips = 0;
  int m_have = 0;
  int m_prev = 0;

  always #10 clk = ~clk;

  fine_bb_loop dut_i (
    .clk(clk), .rst_n(rst_n), .coarse_lock(coarse_lock), .dec_valid(dec_valid),
    .dec_late(dec_late), .fine_code(fine_code), .bw_low(bw_low)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic c, input logic v, input logic l);
    int st;
    if (!c) begin
      m_code = 256; m_narrow = 0; m_flips = 0; m_have = 0;
    end else if (v) begin
      st = m_narrow ? 1 : 16;
      if (l) m_code = (m_code + st > 511) ? 511 : m_code + st;
      else   m_code = (m_code - st < 0) ? 0 : m_code - st;
      if (m_have && (int'(l) != m_prev)) begin
        m_flips++;
        if (m_flips >= 4) m_narrow = 1;
      end
      m_prev = int'(l);
      m_have = 1;
    end
  endtask

  task automatic tick(input logic c, input logic v, input logic l);
    @(negedge clk);
    chk(fine_code == 9'(m_code), {req, " code"}, int'(fine_code), m_code);
    chk(bw_low == 1'(m_narrow), {req, " bw_low"}, int'(bw_low), m_narrow);
    coarse_lock = c; dec_valid = v; dec_late = l;
    model_step(c, v, l);
  endtask

  task automatic burst(input logic l, input int gap);
    tick(1'b1, 1'b1, l);
    for (int i = 0; i < gap; i++) tick(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    chk(fine_code == 9'd256, "R1 reset code", int'(fine_code), 256);
    chk(bw_low == 1'b0, "R1 reset bw_low", int'(bw_low), 0);
    rst_n = 1'b1;

    req = "R8";
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1, 1'(i % 2));
    tick(1'b0, 1'b0, 1'b0);
    chk(fine_code == 9'd256, "R8 unlocked strobes ignored", int'(fine_code), 256);

    req = "R5";
    burst(1'b1, 3); burst(1'b1, 3); burst(1'b1, 3);
    chk(fine_code == 9'd304, "R5 three wide steps up", int'(fine_code), 304);
    req = "R4";
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, 1'b1);
    chk(fine_code == 9'd304, "R4 hold between bursts", int'(fine_code), 304);

    req = "R6";
    burst(1'b0, 2);
    burst(1'b1, 2);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    burst(1'b0, 2);
    burst(1'b1, 2); burst(1'b0, 2); burst(1'b1, 2);
    chk(bw_low == 1'b0, "R6 three flips still wide", int'(bw_low), 0);
    burst(1'b0, 2);
    chk(bw_low == 1'b1, "R6 narrow after fourth flip", int'(bw_low), 1);
    burst(1'b1, 2);
    req = "R3";
    burst(1'b1, 2);
    burst(1'b0, 2);

    req = "R2";
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0);
    chk(fine_code == 9'd256, "R2 parked at mid", int'(fine_code), 256);
    chk(bw_low == 1'b0, "R2 wide after unlock", int'(bw_low), 0);

    req = "R7";
    for (int i = 0; i < 20; i++) burst(1'b1, 1);
    chk(fine_code == 9'd511, "R7 top limit", int'(fine_code), 511);
    tick(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) burst(1'b0, 1);
    chk(fine_code == 9'd0, "R7 bottom limit", int'(fine_code), 0);

    req = "R3";
    for (int i = 0; i < 3000; i++) begin
      logic c, v, l;
      c = ($urandom % 64) != 0;
      v = ($urandom % 4) == 0;
      l = 1'($urandom % 2);
      tick(c, v, l);
    end
    tick(1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule